// File: doc/BRIEF.md
# Voice Record and Playback Sequencer

This block is the top-level sequencer of a single-channel 8-bit voice recorder. Three push buttons (record, play, erase) drive it. While record is held, it starts one analog conversion per sample frame. It then passes the upper byte of each result to a serial-flash write port at consecutive addresses. While play is held, it fetches the stored bytes in the same order and presents each one as the duty value of a PWM stage. Erase asks the flash for a whole-memory wipe and shows completion on a status LED.

Every sample frame is one PWM period of `FRAME_LEN` clocks (256 by default), so capture and playback run at the same rate. A byte fetched during one frame becomes the duty value at the start of the next frame. The block keeps separate write and read address counters. The write counter refuses to go past the final address, and playback stops once the read counter catches up with the write counter. The flash signalling itself, the converter and the PWM counter lie outside this block.

Top module: `voice_seq_ctrl`

## Requirements
- R1: After reset all LEDs and all request strobes are low, `pwm_duty` is the mid-scale value 0x80 and no flash access is pending.
- R2: Each button passes through a two-stage synchronizer and a debouncer. A level that holds for fewer than `DEB_LEN` clocks has no effect.
- R3: While record is held, exactly one `adc_start` pulse is issued, in the clock after a `frame_sync` pulse. Each `adc_done` causes one `fl_wr_req` carrying `adc_data` at the next write address. Addresses start at zero and rise by one per sample.
- R4: Once record is released, no new conversion starts at later frame boundaries. A conversion already running still completes and is written. `led_rec` then falls.
- R5: If the write address equals 2^ADDR_W-1 when a capture is due, no capture takes place, recording ends and `led_full` is set. That last address is never written.
- R6: While play is held, one `fl_rd_req` is issued per frame, in the clock after `frame_sync`, for the current read address. The returned bytes appear on `pwm_duty` in write order, each at the following frame boundary. `pwm_duty` changes only in the clock after `frame_sync`.
- R7: When the read address equals the write address at a frame boundary (or when play is requested), no read is issued, playback ends or does not begin, and `led_empty` is set.
- R8: Commands are served with fixed priority: record over play over erase.
- R9: No command starts while `fl_busy` is high. At most one of `fl_wr_req`, `fl_rd_req`, `fl_erase_req` is high in any cycle.
- R10: An erase press from idle issues one `fl_erase_req`. When the flash has been busy and then goes idle, both addresses return to zero, `led_full` and `led_empty` clear and `led_erased` is set. `led_erased` clears when recording next begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_rec | input | 1 | Raw record button, high when pressed |
| btn_play | input | 1 | Raw play button, high when pressed |
| btn_erase | input | 1 | Raw erase button, high when pressed |
| adc_start | output | 1 | One-clock conversion start strobe |
| adc_done | input | 1 | One-clock conversion complete strobe |
| adc_data | input | SAMP_W | Upper byte of the left-adjusted conversion result, valid with `adc_done` |
| fl_wr_req | output | 1 | One-clock flash byte write request |
| fl_rd_req | output | 1 | One-clock flash byte read request |
| fl_erase_req | output | 1 | One-clock whole-memory erase request |
| fl_addr | output | ADDR_W | Byte address for write or read |
| fl_wdata | output | SAMP_W | Byte to write |
| fl_rdata | input | SAMP_W | Byte read, valid with `fl_rd_valid` |
| fl_rd_valid | input | 1 | One-clock read data strobe |
| fl_busy | input | 1 | Flash engine busy |
| frame_sync | output | 1 | One-clock pulse at each frame (PWM period) start |
| pwm_duty | output | SAMP_W | Duty value for the PWM stage |
| led_rec | output | 1 | Recording in progress |
| led_play | output | 1 | Playback in progress |
| led_full | output | 1 | Memory full |
| led_empty | output | 1 | No unplayed data |
| led_erased | output | 1 | Erase completed |

## Verification
The bench records until the write counter stops short of the final address. A design with an off-by-one in the full test would write that address or stop one sample early. It releases record while a conversion is in flight and holds record and play together, so a sequencer that drops the pending sample, keeps converting, or lets play win would be caught. Playback is run until the counters meet, and every duty change is compared against the recorded stream and tied to a frame boundary. A design that updates the duty as soon as data returns, or skips or repeats a byte, shows up here. Glitch-length presses, presses during forced flash-busy, and a play request directly after an erase check that short pulses and busy periods are ignored and that erase really clears both counters.

// File: rtl/vsq_pkg.sv
package vsq_pkg;

  localparam int BTN_N     = 3;
  localparam int BTN_REC   = 0;
  localparam int BTN_PLAY  = 1;
  localparam int BTN_ERASE = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REC_WAIT,
    ST_REC_CONV,
    ST_PLAY_WAIT,
    ST_PLAY_FETCH,
    ST_ERASE
  } vsq_state_t;

endpackage

// File: rtl/vsq_debounce.sv
module vsq_debounce #(
  parameter int DEB_LEN = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic level
);
  localparam int CW = (DEB_LEN > 1) ? $clog2(DEB_LEN) : 1;

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      cnt   <= '0;
      level <= 1'b0;
    end else begin
      s1 <= raw_in;
      s2 <= s1;
      if (s2 == level) begin
        cnt <= '0;
      end else if (cnt == CW'(DEB_LEN - 1)) begin
        level <= s2;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2: the filtered level only moves toward what the synchronizer shows
  p_flip_needs_input_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(level) |-> ($past(s2) == level));

endmodule

// File: rtl/vsq_frame_timer.sv
module vsq_frame_timer #(
  parameter int FRAME_LEN = 256
) (
  input  logic clk,
  input  logic rst,
  output logic frame_sync
);
  localparam int FW = $clog2(FRAME_LEN);

  logic [FW-1:0] fcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt       <= '0;
      frame_sync <= 1'b0;
    end else begin
      frame_sync <= (fcnt == FW'(FRAME_LEN - 1));
      if (fcnt == FW'(FRAME_LEN - 1)) fcnt <= '0;
      else                            fcnt <= fcnt + 1'b1;
    end
  end

  // R6: frame pulses are single-cycle
  p_sync_single_r6: assert property (@(posedge clk) disable iff (rst)
    frame_sync |=> !frame_sync);

endmodule

// File: rtl/vsq_addr_ptrs.sv
module vsq_addr_ptrs #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              w_inc,
  input  logic              r_inc,
  input  logic              clr,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W-1:0] raddr,
  output logic              at_full,
  output logic              at_empty
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      waddr <= '0;
      raddr <= '0;
    end else begin
      if (w_inc) waddr <= waddr + 1'b1;
      if (r_inc) raddr <= raddr + 1'b1;
    end
  end

  assign at_full  = (waddr == LAST);
  assign at_empty = (raddr == waddr);

  // R3: the write address never moves backward except by erase
  p_waddr_rising_r3: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (waddr >= $past(waddr)));
  // R5: no increment out of the final address
  p_no_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    w_inc |-> (waddr != LAST));
  // R10: erase returns both counters to zero
  p_clear_zero_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (waddr == '0 && raddr == '0));
  // R7: the read counter never overtakes the write counter
  p_read_behind_r7: assert property (@(posedge clk) disable iff (rst)
    r_inc |-> !at_empty);

endmodule

// File: rtl/voice_seq_ctrl.sv
module voice_seq_ctrl
  import vsq_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int SAMP_W    = 8,
  parameter int FRAME_LEN = 256,
  parameter int DEB_LEN   = 50000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              btn_rec,
  input  logic              btn_play,
  input  logic              btn_erase,
  output logic              adc_start,
  input  logic              adc_done,
  input  logic [SAMP_W-1:0] adc_data,
  output logic              fl_wr_req,
  output logic              fl_rd_req,
  output logic              fl_erase_req,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [SAMP_W-1:0] fl_wdata,
  input  logic [SAMP_W-1:0] fl_rdata,
  input  logic              fl_rd_valid,
  input  logic              fl_busy,
  output logic              frame_sync,
  output logic [SAMP_W-1:0] pwm_duty,
  output logic              led_rec,
  output logic              led_play,
  output logic              led_full,
  output logic              led_empty,
  output logic              led_erased
);
  localparam logic [SAMP_W-1:0] DUTY_MID = SAMP_W'(1) << (SAMP_W - 1);
  localparam logic [ADDR_W-1:0] LAST     = '1;

  // button conditioning
  logic [BTN_N-1:0] raw, lv;
  assign raw = {btn_erase, btn_play, btn_rec};

  for (genvar g = 0; g < BTN_N; g++) begin : g_btn
    vsq_debounce #(.DEB_LEN(DEB_LEN)) u_db (
      .clk    (clk),
      .rst    (rst),
      .raw_in (raw[g]),
      .level  (lv[g])
    );
  end

  logic erase_q;
  logic erase_press;
  assign erase_press = lv[BTN_ERASE] & ~erase_q;

  // frame timing
  vsq_frame_timer #(.FRAME_LEN(FRAME_LEN)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .frame_sync (frame_sync)
  );

  // address counters
  logic              w_inc, r_inc, ptr_clr, at_full, at_empty;
  logic [ADDR_W-1:0] waddr, raddr;

  vsq_addr_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
    .clk      (clk),
    .rst      (rst),
    .w_inc    (w_inc),
    .r_inc    (r_inc),
    .clr      (ptr_clr),
    .waddr    (waddr),
    .raddr    (raddr),
    .at_full  (at_full),
    .at_empty (at_empty)
  );

  // sequencer
  vsq_state_t        state, nxt;
  logic              adc_go, wr_go, rd_go, er_go;
  logic              set_full, set_empty, load_duty, fetch_ok, erase_done;
  logic              er_seen, pend;
  logic [SAMP_W-1:0] next_byte;
  logic              rec_entry;

  always_comb begin
    nxt        = state;
    adc_go     = 1'b0;
    wr_go      = 1'b0;
    rd_go      = 1'b0;
    er_go      = 1'b0;
    w_inc      = 1'b0;
    r_inc      = 1'b0;
    ptr_clr    = 1'b0;
    set_full   = 1'b0;
    set_empty  = 1'b0;
    load_duty  = 1'b0;
    fetch_ok   = 1'b0;
    erase_done = 1'b0;
    case (state)
      ST_IDLE: begin
        if (!fl_busy) begin
          if (lv[BTN_REC]) begin
            if (at_full) set_full = 1'b1;
            else         nxt = ST_REC_WAIT;
          end else if (lv[BTN_PLAY]) begin
            if (at_empty) set_empty = 1'b1;
            else          nxt = ST_PLAY_WAIT;
          end else if (erase_press) begin
            er_go = 1'b1;
            nxt   = ST_ERASE;
          end
        end
      end
      ST_REC_WAIT: begin
        if (frame_sync) begin
          if (!lv[BTN_REC]) begin
            nxt = ST_IDLE;
          end else if (at_full) begin
            set_full = 1'b1;
            nxt      = ST_IDLE;
          end else begin
            adc_go = 1'b1;
            nxt    = ST_REC_CONV;
          end
        end
      end
      ST_REC_CONV: begin
        if (adc_done) begin
          wr_go = 1'b1;
          w_inc = 1'b1;
          nxt   = ST_REC_WAIT;
        end
      end
      ST_PLAY_WAIT: begin
        if (frame_sync) begin
          load_duty = pend;
          if (!lv[BTN_PLAY]) begin
            nxt = ST_IDLE;
          end else if (at_empty) begin
            set_empty = 1'b1;
            nxt       = ST_IDLE;
          end else begin
            rd_go = 1'b1;
            nxt   = ST_PLAY_FETCH;
          end
        end
      end
      ST_PLAY_FETCH: begin
        if (fl_rd_valid) begin
          fetch_ok = 1'b1;
          r_inc    = 1'b1;
          nxt      = ST_PLAY_WAIT;
        end
      end
      ST_ERASE: begin
        if (er_seen && !fl_busy) begin
          erase_done = 1'b1;
          ptr_clr    = 1'b1;
          nxt        = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign rec_entry = (state == ST_IDLE) && (nxt == ST_REC_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      erase_q      <= 1'b0;
      adc_start    <= 1'b0;
      fl_wr_req    <= 1'b0;
      fl_rd_req    <= 1'b0;
      fl_erase_req <= 1'b0;
      fl_addr      <= '0;
      fl_wdata     <= '0;
      pwm_duty     <= DUTY_MID;
      next_byte    <= '0;
      pend         <= 1'b0;
      er_seen      <= 1'b0;
      led_rec      <= 1'b0;
      led_play     <= 1'b0;
      led_full     <= 1'b0;
      led_empty    <= 1'b0;
      led_erased   <= 1'b0;
    end else begin
      state        <= nxt;
      erase_q      <= lv[BTN_ERASE];
      adc_start    <= adc_go;
      fl_wr_req    <= wr_go;
      fl_rd_req    <= rd_go;
      fl_erase_req <= er_go;
      if (wr_go) begin
        fl_addr  <= waddr;
        fl_wdata <= adc_data;
      end else if (rd_go) begin
        fl_addr <= raddr;
      end
      if (fetch_ok) begin
        next_byte <= fl_rdata;
        pend      <= 1'b1;
      end else if (load_duty) begin
        pend <= 1'b0;
      end
      if (load_duty) pwm_duty <= next_byte;
      if (er_go)                                 er_seen <= 1'b0;
      else if (state == ST_ERASE && fl_busy)     er_seen <= 1'b1;
      led_rec  <= (nxt == ST_REC_WAIT) || (nxt == ST_REC_CONV);
      led_play <= (nxt == ST_PLAY_WAIT) || (nxt == ST_PLAY_FETCH);
      if (erase_done)    led_full <= 1'b0;
      else if (set_full) led_full <= 1'b1;
      if (erase_done || w_inc) led_empty <= 1'b0;
      else if (set_empty)      led_empty <= 1'b1;
      if (er_go || rec_entry) led_erased <= 1'b0;
      else if (erase_done)    led_erased <= 1'b1;
    end
  end

  // R9: one flash request at a time
  p_single_req_r9: assert property (@(posedge clk) disable iff (rst)
    $countones({fl_wr_req, fl_rd_req, fl_erase_req}) <= 1);
  // R9: erase only leaves while the flash was idle
  p_erase_idle_r9: assert property (@(posedge clk) disable iff (rst)
    fl_erase_req |-> $past(!fl_busy));
  // R5: the final address is never written
  p_no_last_write_r5: assert property (@(posedge clk) disable iff (rst)
    fl_wr_req |-> (fl_addr != LAST));
  // R6: the duty value moves only at a frame start
  p_duty_on_frame_r6: assert property (@(posedge clk) disable iff (rst)
    !frame_sync |=> $stable(pwm_duty));
  // R7: reads are never issued for unwritten data
  p_read_nonempty_r7: assert property (@(posedge clk) disable iff (rst)
    fl_rd_req |-> !at_empty);
  // R3: conversions start only during a recording
  p_conv_in_rec_r3: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> led_rec);

endmodule

// File: tb/voice_seq_ctrl_bench.sv
module voice_seq_ctrl_bench;
  localparam int AW = 4;
  localparam int FL = 32;
  localparam int DL = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          btn_rec = 0, btn_play = 0, btn_erase = 0;
  logic          adc_start, adc_done = 0;
  logic [7:0]    adc_data = 0;
  logic          fl_wr_req, fl_rd_req, fl_erase_req;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_wdata, fl_rdata = 0;
  logic          fl_rd_valid = 0, fl_busy = 0;
  logic          frame_sync;
  logic [7:0]    pwm_duty;
  logic          led_rec, led_play, led_full, led_empty, led_erased;

  voice_seq_ctrl #(.ADDR_W(AW), .SAMP_W(8), .FRAME_LEN(FL), .DEB_LEN(DL)) u_voice_seq_ctrl (
    .clk, .rst, .btn_rec, .btn_play, .btn_erase,
    .adc_start, .adc_done, .adc_data,
    .fl_wr_req, .fl_rd_req, .fl_erase_req, .fl_addr, .fl_wdata,
    .fl_rdata, .fl_rd_valid, .fl_busy,
    .frame_sync, .pwm_duty,
    .led_rec, .led_play, .led_full, .led_empty, .led_erased
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard state
  logic [AW+7:0] wq[$];
  logic [7:0]    dq[$];
  logic [7:0]    rec_vals[64];
  int            nrec = 0, ks = 0, exp_waddr = 0;
  int            adc_cnt = 0, rd_cnt = 0, busy_cnt = 0;
  int            wr_seen = 0, starts = 0, erase_reqs = 0, duty_seen = 0;
  logic [7:0]    adc_val = 0, mem [16];
  logic [AW-1:0] rd_addr = 0;
  logic          force_busy = 0, prev_sync = 0;
  logic [7:0]    last_duty = 8'h80;

  // converter and flash models plus monitors
  always @(negedge clk) begin
    if (!rst) begin
      adc_done = 1'b0;
      if (adc_cnt != 0) begin
        adc_cnt--;
        if (adc_cnt == 0) begin adc_done = 1'b1; adc_data = adc_val; end
      end
      if (adc_start) begin
        if (!prev_sync) chk(0, "R3", "adc_start off frame", 0, 1);
        adc_val = 8'h10 + 8'(7 * ks);
        ks++;
        starts++;
        wq.push_back({AW'(exp_waddr), adc_val});
        rec_vals[nrec] = adc_val;
        nrec++;
        exp_waddr++;
        adc_cnt = 12;
      end
      fl_rd_valid = 1'b0;
      if (rd_cnt != 0) begin
        rd_cnt--;
        if (rd_cnt == 0) begin fl_rd_valid = 1'b1; fl_rdata = mem[rd_addr]; end
      end
      if (busy_cnt != 0) busy_cnt--;
      if (fl_wr_req) begin
        logic [AW+7:0] e;
        wr_seen++;
        if (fl_addr == AW'(2**AW - 1)) chk(0, "R5", "write to final address", int'(fl_addr), 2**AW - 2);
        if (wq.size() == 0) chk(0, "R3", "unexpected write", int'(fl_addr), -1);
        else begin
          e = wq.pop_front();
          chk({fl_addr, fl_wdata} == e, "R3", "write addr/data", int'({fl_addr, fl_wdata}), int'(e));
        end
        mem[fl_addr] = fl_wdata;
        busy_cnt = 6;
      end
      if (fl_rd_req) begin
        if (!prev_sync) chk(0, "R6", "read off frame", 0, 1);
        rd_addr = fl_addr; rd_cnt = 10; busy_cnt = 10;
      end
      if (fl_erase_req) begin busy_cnt = 20; erase_reqs++; end
      fl_busy = (busy_cnt != 0) || force_busy;
      if (pwm_duty != last_duty) begin
        if (!prev_sync) chk(0, "R6", "duty change off frame", 0, 1);
        if (dq.size() == 0) chk(0, "R6", "unexpected duty", int'(pwm_duty), -1);
        else begin
          logic [7:0] d;
          d = dq.pop_front();
          chk(pwm_duty == d, "R6", "duty value", int'(pwm_duty), int'(d));
        end
        duty_seen++;
        last_duty = pwm_duty;
      end
      prev_sync = frame_sync;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int n, snap;
    wait_cyc(6);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk({led_rec, led_play, led_full, led_empty, led_erased} == 0, "R1", "leds", 0, 0);
    chk(pwm_duty == 8'h80, "R1", "duty mid", int'(pwm_duty), 128);
    chk({adc_start, fl_wr_req, fl_rd_req, fl_erase_req} == 0, "R1", "strobes", 0, 0);

    // R2 short glitch ignored
    btn_rec = 1; wait_cyc(2); btn_rec = 0;
    wait_cyc(FL + 10);
    chk(!led_rec, "R2", "glitch led_rec", int'(led_rec), 0);
    chk(starts == 0, "R2", "glitch conversions", starts, 0);

    // R8 record beats play
    btn_rec = 1; btn_play = 1;
    wait_cyc(15);
    chk(led_rec && !led_play, "R8", "rec over play", int'({led_rec, led_play}), 2);
    btn_play = 0;
    wait_cyc(5 * FL);
    btn_rec = 0;
    wait_cyc(80);
    snap = starts;
    wait_cyc(3 * FL);
    chk(starts == snap, "R4", "no conversion after release", starts, snap);
    chk(!led_rec, "R4", "led_rec after release", int'(led_rec), 0);
    chk(wq.size() == 0 && wr_seen == nrec, "R3", "writes per sample", wr_seen, nrec);

    // R6/R7 playback to empty
    for (int i = 0; i < nrec; i++) dq.push_back(rec_vals[i]);
    btn_play = 1;
    n = 0;
    while (!led_empty && n < (nrec + 4) * FL) begin @(negedge clk); n++; end
    wait_cyc(3);
    chk(led_empty == 1, "R7", "led_empty", int'(led_empty), 1);
    chk(!led_play, "R7", "play stops when empty", int'(led_play), 0);
    chk(duty_seen == nrec, "R6", "duty updates", duty_seen, nrec);
    chk(pwm_duty == rec_vals[nrec-1], "R6", "final duty", int'(pwm_duty), int'(rec_vals[nrec-1]));
    btn_play = 0;
    wait_cyc(10);

    // R9 busy blocks commands
    force_busy = 1; btn_rec = 1;
    wait_cyc(40);
    chk(!led_rec, "R9", "rec blocked by busy", int'(led_rec), 0);
    force_busy = 0;
    wait_cyc(5);
    chk(led_rec == 1, "R9", "rec after busy", int'(led_rec), 1);

    // R5 record up to full
    n = 0;
    while (!led_full && n < 40 * FL) begin @(negedge clk); n++; end
    wait_cyc(3);
    chk(led_full == 1, "R5", "led_full", int'(led_full), 1);
    chk(!led_rec, "R5", "rec ends at full", int'(led_rec), 0);
    chk(wr_seen == 2**AW - 1, "R5", "total writes", wr_seen, 2**AW - 1);
    btn_play = 1;
    wait_cyc(2 * FL);
    chk(!led_play, "R8", "rec held blocks play", int'(led_play), 0);
    btn_play = 0; btn_rec = 0;
    wait_cyc(20);

    // R10 erase
    btn_erase = 1; wait_cyc(10); btn_erase = 0;
    n = 0;
    while (!led_erased && n < 200) begin @(negedge clk); n++; end
    wait_cyc(2);
    chk(erase_reqs == 1, "R10", "erase requests", erase_reqs, 1);
    chk(led_erased && !led_full, "R10", "erase leds", int'({led_erased, led_full}), 2);
    exp_waddr = 0;
    btn_play = 1; wait_cyc(20);
    chk(led_empty && !led_play, "R10", "empty after erase", int'({led_empty, led_play}), 2);
    btn_play = 0; wait_cyc(10);
    snap = wr_seen;
    btn_rec = 1;
    n = 0;
    while (wr_seen == snap && n < 4 * FL) begin @(negedge clk); n++; end
    chk(!led_erased, "R10", "erased led clears on record", int'(led_erased), 0);
    btn_rec = 0;
    wait_cyc(4 * FL);
    chk(wq.size() == 0, "R10", "write restarts at zero", wq.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule